// File: doc/BRIEF.md
# Overflow Recovery Hit Decoder

This block sits between a pixel-line FIFO and the hit writer of a readout channel. It takes 16-bit chip lines from the FIFO and turns each set bit into a hit address. The address is the bit index, and it comes out with a write strobe. Under normal conditions no hit is dropped: a line is held until every set bit has been emitted, one per clock.

When the recovery feature is switched on and the FIFO backs up to a high water mark, the block changes to a lossy drain mode. In that mode it takes one line every clock and emits only the lowest set bit of each line. It stays in this mode until the FIFO has drained to a low water mark, and then normal decoding resumes.

Any line that loses hits in drain mode raises two sticky flags: one for the current event and one for the current chip. The block uses these flags to set the error bit in the chip trailer word and the loss bit in the event error word that pass through it. Both flags are cleared by the boundary strobes.

Top module: `ovr_recov_dec`

## Requirements
- R1: After reset, recov_active, hit_valid, event_loss and chip_loss are 0, line_ready is 1, and trailer_out and errword_out equal their inputs.
- R2: Recovery is allowed only when bit 2 of ctl_a and bit 2 of ctl_b are both 1. This enable is registered, so it takes effect one clock after it is applied. The other control bits have no effect.
- R3: While recovery is allowed and the block is in normal mode, a fifo_level of 500 or more switches recov_active on at the next clock edge. A level of 499 does not.
- R4: While in recovery, a fifo_level of 100 or less switches recov_active off at the next edge, and a level of 101 keeps it on. Losing the registered enable also forces normal mode at the next edge.
- R5: In normal mode, a line is taken when line_valid and line_ready are both 1. Every set bit is emitted as one hit per clock, lowest index first. line_ready stays 0 until the cycle after the last hit is registered. A line with no bits set is taken in one clock and emits no hit.
- R6: In recovery mode, line_ready stays 1 and one line is taken per clock. Each line emits a single hit at its lowest set bit, or no hit if the line is zero.
- R7: hit_valid and hit_idx show a hit on the clock edge that takes the bit, so they are visible in the following cycle.
- R8: A line taken in recovery mode with more than one bit set sets event_loss and chip_loss at that edge. A line with zero or one bit set does not.
- R9: chip_start clears chip_loss only. event_start clears both flags. A loss in the same cycle as a strobe wins, so the flag stays set.
- R10: trailer_out is trailer_in with bit 12 ORed with chip_loss. errword_out is errword_in with bit 0 ORed with event_loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_a | input | 5 | Control word of channel A, bit 2 = recovery enable |
| ctl_b | input | 5 | Control word of channel B, bit 2 = recovery enable |
| fifo_level | input | 10 | Current FIFO occupancy |
| line_valid | input | 1 | A 16-bit line is offered |
| line_data | input | 16 | Line bits, one per pixel |
| line_ready | output | 1 | Block takes the offered line this cycle |
| event_start | input | 1 | Strobe marking the start of a new event |
| chip_start | input | 1 | Strobe marking the start of a new chip |
| trailer_in | input | 16 | Chip trailer word to be marked |
| errword_in | input | 16 | Event error word to be marked |
| hit_valid | output | 1 | Write strobe for one hit |
| hit_idx | output | 4 | Bit index of the hit within its line |
| recov_active | output | 1 | Lossy drain mode is active |
| event_loss | output | 1 | Hits were dropped in the current event |
| chip_loss | output | 1 | Hits were dropped in the current chip |
| trailer_out | output | 16 | Trailer with the loss bit applied |
| errword_out | output | 16 | Error word with the loss bit applied |

## Verification
In normal mode the decoder is given a line with four scattered bits, a zero line, and a two-bit line. These show the lowest-first order, that line_ready is held back while bits remain, and that an empty line is skipped with no hit. In drain mode the bench feeds a zero line, a single-bit line and a multi-bit line on back-to-back clocks. This separates "no hit", "hit without loss" and "hit with loss", and also checks that no back-pressure appears. Levels of 499/500 and 101/100, a single-channel enable, a dropped enable, and strobes that coincide with a loss each probe one edge of the hysteresis or of the flag clearing.

// File: rtl/ovr_pkg.sv
package ovr_pkg;
    localparam int LINE_W      = 16;
    localparam int IDX_W       = $clog2(LINE_W);
    localparam int LVL_W       = 10;
    localparam int HI_MARK     = 500;
    localparam int LO_MARK     = 100;
    localparam int CTL_W       = 5;
    localparam int EN_BIT      = 2;
    localparam int WORD_W      = 16;
    localparam int TRL_ERR_BIT = 12;
    localparam int EVT_ERR_BIT = 0;

    typedef enum logic {
        MODE_NORMAL  = 1'b0,
        MODE_RECOVER = 1'b1
    } mode_e;

    typedef struct packed {
        logic             vld;
        logic [IDX_W-1:0] idx;
    } hit_t;

    // index of the lowest set bit (0 when no bit is set)
    function automatic logic [IDX_W-1:0] lsb_index(input logic [LINE_W-1:0] v);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int i = LINE_W - 1; i >= 0; i--) begin
            if (v[i]) r = IDX_W'(i);
        end
        return r;
    endfunction

    function automatic logic [LINE_W-1:0] lsb_isolate(input logic [LINE_W-1:0] v);
        return v & (~v + LINE_W'(1));
    endfunction
endpackage

// File: rtl/ovr_hyst.sv
module ovr_hyst
    import ovr_pkg::*;
#(
    parameter int LW  = LVL_W,
    parameter int HI  = HI_MARK,
    parameter int LO  = LO_MARK,
    parameter int CW  = CTL_W,
    parameter int ENB = EN_BIT
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] ctl_a,
    input  logic [CW-1:0] ctl_b,
    input  logic [LW-1:0] level,
    output mode_e         mode,
    output logic          en_q
);
    localparam logic [LW-1:0] HI_L = LW'(HI);
    localparam logic [LW-1:0] LO_L = LW'(LO);

    logic unused_ctl;
    assign unused_ctl = ^{ctl_a, ctl_b};

    mode_e mode_n;

    always_comb begin
        mode_n = mode;
        if (!en_q)
            mode_n = MODE_NORMAL;
        else if (mode == MODE_NORMAL && level >= HI_L)
            mode_n = MODE_RECOVER;
        else if (mode == MODE_RECOVER && level <= LO_L)
            mode_n = MODE_NORMAL;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= 1'b0;
            mode <= MODE_NORMAL;
        end else begin
            en_q <= ctl_a[ENB] & ctl_b[ENB];
            mode <= mode_n;
        end
    end

    assert_disable_exit_R4: assert property (@(posedge clk) disable iff (rst)
        !en_q |=> mode == MODE_NORMAL);
    assert_hold_above_low_R4: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_RECOVER && en_q && level > LO_L) |=> mode == MODE_RECOVER);
    assert_no_entry_below_R3: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_NORMAL && level < HI_L) |=> mode == MODE_NORMAL);
endmodule

// File: rtl/ovr_line_dec.sv
module ovr_line_dec
    import ovr_pkg::*;
#(
    parameter int LW = LINE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  mode_e         mode,
    input  logic          line_valid,
    input  logic [LW-1:0] line_data,
    output logic          line_ready,
    output hit_t          hit,
    output logic          lossy_take
);
    logic [LW-1:0] work_q;
    logic [LW-1:0] sel;
    logic [LW-1:0] low;
    logic [LW-1:0] rest;
    logic          busy;
    logic          take;

    assign busy       = |work_q;
    assign line_ready = !busy;
    assign sel        = busy ? work_q : line_data;
    assign take       = busy || line_valid;
    assign low        = lsb_isolate(sel);
    assign rest       = sel & ~low;
    assign lossy_take = take && (mode == MODE_RECOVER) && (|rest);

    always_ff @(posedge clk) begin
        if (rst) begin
            work_q  <= '0;
            hit.vld <= 1'b0;
            hit.idx <= '0;
        end else begin
            if (take)
                work_q <= (mode == MODE_RECOVER) ? '0 : rest;
            hit.vld <= take && (|sel);
            hit.idx <= lsb_index(sel);
        end
    end

    // R6: after one recovery cycle nothing is held back
    assert_drain_one_line_R6: assert property (@(posedge clk) disable iff (rst)
        mode == MODE_RECOVER |=> (mode == MODE_RECOVER) -> (work_q == '0));
    // R5: held bits always yield a hit at the next edge
    assert_held_bits_emit_R5: assert property (@(posedge clk) disable iff (rst)
        busy |=> hit.vld);
    // R8: losses only arise in recovery mode
    assert_loss_in_recovery_R8: assert property (@(posedge clk) disable iff (rst)
        lossy_take |-> mode == MODE_RECOVER);
endmodule

// File: rtl/ovr_loss_mark.sv
module ovr_loss_mark
    import ovr_pkg::*;
#(
    parameter int WW  = WORD_W,
    parameter int TEB = TRL_ERR_BIT,
    parameter int EEB = EVT_ERR_BIT
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          lossy_take,
    input  logic          event_start,
    input  logic          chip_start,
    input  logic [WW-1:0] trailer_in,
    input  logic [WW-1:0] errword_in,
    output logic          event_loss,
    output logic          chip_loss,
    output logic [WW-1:0] trailer_out,
    output logic [WW-1:0] errword_out
);
    logic chip_clr;
    assign chip_clr = chip_start || event_start;

    always_ff @(posedge clk) begin
        if (rst) begin
            event_loss <= 1'b0;
            chip_loss  <= 1'b0;
        end else begin
            event_loss <= lossy_take || (event_loss && !event_start);
            chip_loss  <= lossy_take || (chip_loss && !chip_clr);
        end
    end

    always_comb begin
        trailer_out      = trailer_in;
        trailer_out[TEB] = trailer_in[TEB] | chip_loss;
        errword_out      = errword_in;
        errword_out[EEB] = errword_in[EEB] | event_loss;
    end

    assert_loss_sets_flags_R8: assert property (@(posedge clk) disable iff (rst)
        lossy_take |=> event_loss && chip_loss);
    assert_event_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (event_start && !lossy_take) |=> !event_loss && !chip_loss);
    assert_chip_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (chip_start && !event_start && !lossy_take) |=> !chip_loss && (event_loss == $past(event_loss)));
endmodule

// File: rtl/ovr_recov_dec.sv
module ovr_recov_dec
    import ovr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CTL_W-1:0]  ctl_a,
    input  logic [CTL_W-1:0]  ctl_b,
    input  logic [LVL_W-1:0]  fifo_level,
    input  logic              line_valid,
    input  logic [LINE_W-1:0] line_data,
    output logic              line_ready,
    input  logic              event_start,
    input  logic              chip_start,
    input  logic [WORD_W-1:0] trailer_in,
    input  logic [WORD_W-1:0] errword_in,
    output logic              hit_valid,
    output logic [IDX_W-1:0]  hit_idx,
    output logic              recov_active,
    output logic              event_loss,
    output logic              chip_loss,
    output logic [WORD_W-1:0] trailer_out,
    output logic [WORD_W-1:0] errword_out
);
    mode_e mode;
    logic  en_q;
    hit_t  hit;
    logic  lossy_take;

    ovr_hyst u_hyst (
        .clk   (clk),
        .rst   (rst),
        .ctl_a (ctl_a),
        .ctl_b (ctl_b),
        .level (fifo_level),
        .mode  (mode),
        .en_q  (en_q)
    );

    ovr_line_dec u_dec (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode),
        .line_valid (line_valid),
        .line_data  (line_data),
        .line_ready (line_ready),
        .hit        (hit),
        .lossy_take (lossy_take)
    );

    ovr_loss_mark u_mark (
        .clk         (clk),
        .rst         (rst),
        .lossy_take  (lossy_take),
        .event_start (event_start),
        .chip_start  (chip_start),
        .trailer_in  (trailer_in),
        .errword_in  (errword_in),
        .event_loss  (event_loss),
        .chip_loss   (chip_loss),
        .trailer_out (trailer_out),
        .errword_out (errword_out)
    );

    assign hit_valid    = hit.vld;
    assign hit_idx      = hit.idx;
    assign recov_active = (mode == MODE_RECOVER);

    assert_recovery_needs_enable_R2: assert property (@(posedge clk) disable iff (rst)
        (recov_active && !$past(recov_active)) |-> $past(en_q));
endmodule

// File: tb/ovr_recov_dec_tb.sv
module ovr_recov_dec_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic [4:0]  ctl_a, ctl_b;
    logic [9:0]  fifo_level;
    logic        line_valid;
    logic [15:0] line_data;
    logic        line_ready;
    logic        event_start, chip_start;
    logic [15:0] trailer_in, errword_in;
    logic        hit_valid;
    logic [3:0]  hit_idx;
    logic        recov_active, event_loss, chip_loss;
    logic [15:0] trailer_out, errword_out;

    int total = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    ovr_recov_dec u_dut (
        .clk(clk), .rst(rst), .ctl_a(ctl_a), .ctl_b(ctl_b),
        .fifo_level(fifo_level), .line_valid(line_valid), .line_data(line_data),
        .line_ready(line_ready), .event_start(event_start), .chip_start(chip_start),
        .trailer_in(trailer_in), .errword_in(errword_in), .hit_valid(hit_valid),
        .hit_idx(hit_idx), .recov_active(recov_active), .event_loss(event_loss),
        .chip_loss(chip_loss), .trailer_out(trailer_out), .errword_out(errword_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1; ctl_a = '0; ctl_b = '0; fifo_level = '0;
        line_valid = 1'b0; line_data = '0; event_start = 1'b0; chip_start = 1'b0;
        trailer_in = 16'h0123; errword_in = 16'h0040;
        tick(); tick();
        rst = 1'b0;
        tick();
        chk("R1 recov", recov_active, 0);
        chk("R1 hit_valid", hit_valid, 0);
        chk("R1 flags", {event_loss, chip_loss}, 0);
        chk("R1 ready", line_ready, 1);
        chk("R1 trailer", trailer_out, 16'h0123);
        chk("R1 errword", errword_out, 16'h0040);
    endtask

    task automatic t_normal();
        line_valid = 1'b1; line_data = 16'hA005;
        tick();
        line_valid = 1'b0; line_data = '0;
        chk("R7 first hit valid", hit_valid, 1);
        chk("R5 hit 0", hit_idx, 0);
        chk("R5 ready held", line_ready, 0);
        tick();
        chk("R5 hit 2", {hit_valid, hit_idx}, {1'b1, 4'd2});
        chk("R5 ready held", line_ready, 0);
        tick();
        chk("R5 hit 13", {hit_valid, hit_idx}, {1'b1, 4'd13});
        chk("R5 ready held", line_ready, 0);
        tick();
        chk("R5 hit 15", {hit_valid, hit_idx}, {1'b1, 4'd15});
        chk("R5 ready back", line_ready, 1);
        tick();
        chk("R5 idle", hit_valid, 0);
        line_valid = 1'b1; line_data = 16'h0000;
        tick();
        chk("R5 zero line no hit", hit_valid, 0);
        chk("R5 zero line ready", line_ready, 1);
        line_data = 16'h8001;
        tick();
        line_valid = 1'b0;
        chk("R5 two-bit first", {hit_valid, hit_idx}, {1'b1, 4'd0});
        tick();
        chk("R5 two-bit second", {hit_valid, hit_idx}, {1'b1, 4'd15});
        chk("R8 no loss in normal", {event_loss, chip_loss}, 0);
    endtask

    task automatic t_enable_gate();
        ctl_a = 5'b11011; ctl_b = 5'b00100; fifo_level = 10'd600;
        tick(); tick();
        chk("R2 one channel only", recov_active, 0);
        ctl_a = 5'b00100; ctl_b = 5'b11011;
        tick(); tick();
        chk("R2 other channel only", recov_active, 0);
    endtask

    task automatic t_entry();
        ctl_a = 5'b00100; ctl_b = 5'b00100; fifo_level = 10'd499;
        tick(); tick(); tick();
        chk("R3 499 no entry", recov_active, 0);
        fifo_level = 10'd500;
        tick();
        chk("R3 500 entry", recov_active, 1);
    endtask

    task automatic t_recovery();
        fifo_level = 10'd300;
        chk("R6 ready in recovery", line_ready, 1);
        line_valid = 1'b1; line_data = 16'h0000;
        tick();
        chk("R6 zero line no hit", hit_valid, 0);
        chk("R8 zero line no loss", event_loss, 0);
        line_data = 16'h0100;
        tick();
        chk("R6 single hit", {hit_valid, hit_idx}, {1'b1, 4'd8});
        chk("R8 single bit no loss", {event_loss, chip_loss}, 0);
        chk("R6 ready", line_ready, 1);
        line_data = 16'h8030;
        tick();
        chk("R6 lowest bit", {hit_valid, hit_idx}, {1'b1, 4'd4});
        chk("R8 loss flags", {event_loss, chip_loss}, 2'b11);
        chk("R6 ready after lossy", line_ready, 1);
        chk("R10 trailer bit 12", trailer_out, 16'h1123);
        chk("R10 errword bit 0", errword_out, 16'h0041);
        line_valid = 1'b0;
        tick();
        chk("R6 no held bits", hit_valid, 0);
    endtask

    task automatic t_clear();
        chip_start = 1'b1;
        tick();
        chip_start = 1'b0;
        chk("R9 chip clear", chip_loss, 0);
        chk("R9 event kept", event_loss, 1);
        chk("R10 trailer clean", trailer_out, 16'h0123);
        event_start = 1'b1; line_valid = 1'b1; line_data = 16'h0003;
        tick();
        line_valid = 1'b0;
        chk("R9 loss wins", {event_loss, chip_loss}, 2'b11);
        chk("R6 hit 0", {hit_valid, hit_idx}, {1'b1, 4'd0});
        tick();
        event_start = 1'b0;
        chk("R9 event clear", {event_loss, chip_loss}, 0);
        chk("R10 errword clean", errword_out, 16'h0040);
    endtask

    task automatic t_exit();
        fifo_level = 10'd101;
        tick();
        chk("R4 101 stays", recov_active, 1);
        fifo_level = 10'd100;
        tick();
        chk("R4 100 exits", recov_active, 0);
        fifo_level = 10'd500;
        tick();
        chk("R3 re-entry", recov_active, 1);
        ctl_b = 5'b00000;
        tick();
        chk("R2 enable latency", recov_active, 1);
        tick();
        chk("R4 disable exits", recov_active, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        t_reset();
        t_normal();
        t_enable_gate();
        t_entry();
        t_recovery();
        t_clear();
        t_exit();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule